// File: doc/BRIEF.md
# Background Card Row Fetch and Replay Controller

This block feeds a video pipeline with background card words. It holds a 240-entry card table, which is twelve rows of twenty cards, and a twenty-entry line buffer. A video fetch strobe asks for one card word per rising edge. On a loading scanline the block takes the next word from the table, copies it into the line buffer and presents it. On each of the next fifteen scanlines it presents the buffered row again. A new row is taken only when the bus-acknowledge input is low at the exact strobe where both the card count and the scanline count wrap. An early acknowledge therefore cannot move the display forward, and a late one repeats the whole row.

A CPU port writes and reads the table while the block is out of display mode. A restart pulse from the mode controller puts the block back in CPU mode. The block enters display mode on the first low level of bus-acknowledge that follows. The controller has three states. In IDLE the CPU owns the table and strobes are ignored. In FETCH strobes read the table. In REPLAY strobes read the line buffer. The transitions are as follows:
- IDLE goes to FETCH on acknowledge.
- FETCH or REPLAY goes to FETCH on a wrap strobe that lands on scanline 0 with acknowledge low.
- FETCH or REPLAY goes to REPLAY on any other wrap strobe.
- Any state goes to IDLE on restart.

Top module: `bg_card_ctrl`

## Requirements
- R1: After reset, card_vld_o is 0, cpu_rdata_o is 0, and the block is in CPU mode with all counters at zero.
- R2: In CPU mode, a cycle with cpu_en_i high and cpu_wr_i high writes cpu_wdata_i to table[cpu_addr_i]. A cycle with cpu_en_i high and cpu_wr_i low loads table[cpu_addr_i] into cpu_rdata_o at that clock edge. Entry index = row*20 + card.
- R3: In display mode, CPU writes are dropped and cpu_rdata_o holds its last value.
- R4: In CPU mode, busak_n_i low enters display mode in the loading state. The first strobe then returns table[0].
- R5: A strobe rising edge is a cycle where fetch_i is 1 after a cycle where it was 0. On each such edge in the loading state, the block outputs table[ptr], writes that word to linebuf[card], and increments both ptr and card. card_vld_o is high for exactly the one cycle after the clock edge that sees the rising strobe, and card_o is valid in that cycle.
- R6: On each strobe edge in the replay state, the block outputs linebuf[card] and increments only card.
- R7: When card goes from 19 to 0, the scanline count increments modulo 16. The next strobe is a load only if the new scanline count is 0 and busak_n_i is low at that strobe.
- R8: If acknowledge is high at the row boundary, the same row is replayed for 16 more scanlines. Acknowledge asserted earlier does not advance the row.
- R9: ptr stops at 240, and loads from then on return 0.
- R10: restart_i clears ptr, card and the scanline count, and returns the block to CPU mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_en_i | input | 1 | CPU access request |
| cpu_wr_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 8 | Table entry index |
| cpu_wdata_i | input | 16 | CPU write data |
| cpu_rdata_o | output | 16 | Registered CPU read data |
| busak_n_i | input | 1 | Bus acknowledge, active low |
| fetch_i | input | 1 | Video fetch strobe |
| restart_i | input | 1 | Mode-controller restart (interrupt acknowledge) |
| card_o | output | 16 | Card word to the video pipeline |
| card_vld_o | output | 1 | card_o valid for one cycle |

## Verification
The hardest case to reach is a row boundary where acknowledge is missing. Acknowledge is only sampled on the one strobe in 320 where both counters wrap. The stimulus raises acknowledge for the last scanline of a row, so the boundary passes without it and the block replays the same row. It then lowers acknowledge halfway through the next replay period, well before the boundary. The table is then run past its twelfth row so the saturated pointer returns zeros.

// File: rtl/bgc_pkg.sv
package bgc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_REPLAY = 2'd2
    } bgc_state_e;
endpackage

// File: rtl/bgc_table.sv
module bgc_table #(
    parameter int ENTRIES = 240,
    parameter int DW      = 16,
    parameter int AW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_ok_i,
    input  logic          cpu_en_i,
    input  logic          cpu_wr_i,
    input  logic [AW-1:0] cpu_addr_i,
    input  logic [DW-1:0] cpu_wdata_i,
    output logic [DW-1:0] cpu_rdata_o,
    input  logic [AW-1:0] vid_addr_i,
    output logic [DW-1:0] vid_data_o
);
    logic [DW-1:0] mem [ENTRIES];
    logic          cpu_hit;

    assign cpu_hit = cpu_ok_i && cpu_en_i && (int'(cpu_addr_i) < ENTRIES);

    always_ff @(posedge clk) begin
        if (cpu_hit && cpu_wr_i) mem[cpu_addr_i] <= cpu_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cpu_rdata_o <= '0;
        else if (cpu_ok_i && cpu_en_i && !cpu_wr_i)
            cpu_rdata_o <= cpu_hit ? mem[cpu_addr_i] : '0;
    end

    always_comb begin
        vid_data_o = '0;
        if (int'(vid_addr_i) < ENTRIES) vid_data_o = mem[vid_addr_i];
    end
endmodule

// File: rtl/bgc_linebuf.sv
module bgc_linebuf #(
    parameter int CARDS = 20,
    parameter int DW    = 16,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [CW-1:0] idx_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] buf_q [CARDS];

    always_ff @(posedge clk) begin
        if (we_i && int'(idx_i) < CARDS) buf_q[idx_i] <= wdata_i;
    end

    always_comb begin
        rdata_o = '0;
        if (int'(idx_i) < CARDS) rdata_o = buf_q[idx_i];
    end
endmodule

// File: rtl/bgc_seq.sv
module bgc_seq
    import bgc_pkg::*;
#(
    parameter int CARDS   = 20,
    parameter int LINES   = 16,
    parameter int ENTRIES = 240,
    parameter int CW      = 5,
    parameter int LW      = 4,
    parameter int PW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic          busak_n_i,
    input  logic          rise_i,
    output bgc_state_e    state_o,
    output logic [CW-1:0] card_o,
    output logic [LW-1:0] line_o,
    output logic [PW-1:0] ptr_o
);
    bgc_state_e    state_q, state_d;
    logic [CW-1:0] card_q;
    logic [LW-1:0] line_q, line_nxt;
    logic [PW-1:0] ptr_q;
    logic          wrap, active, step;

    assign wrap     = (card_q == CW'(CARDS - 1));
    assign line_nxt = (line_q == LW'(LINES - 1)) ? '0 : line_q + 1'b1;
    assign active   = (state_q != ST_IDLE);
    assign step     = rise_i && active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!busak_n_i) state_d = ST_FETCH;
            ST_FETCH,
            ST_REPLAY: if (step && wrap)
                           state_d = (line_nxt == '0 && !busak_n_i) ? ST_FETCH : ST_REPLAY;
            default:   state_d = ST_IDLE;
        endcase
        if (restart_i) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            card_q <= '0;
            line_q <= '0;
            ptr_q  <= '0;
        end else if (restart_i) begin
            card_q <= '0;
            line_q <= '0;
            ptr_q  <= '0;
        end else if (step) begin
            card_q <= wrap ? '0 : card_q + 1'b1;
            if (wrap) line_q <= line_nxt;
            if (state_q == ST_FETCH && ptr_q != PW'(ENTRIES)) ptr_q <= ptr_q + 1'b1;
        end
    end

    assign state_o = state_q;
    assign card_o  = card_q;
    assign line_o  = line_q;
    assign ptr_o   = ptr_q;

    p_card_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(card_q) < CARDS);
    p_line_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && wrap && !restart_i) |=>
        line_q == (($past(line_q) == LW'(LINES - 1)) ? LW'(0) : $past(line_q) + 1'b1));
    p_replay_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REPLAY && !restart_i) |=> $stable(ptr_q));
    p_ptr_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr_q) <= ENTRIES);
    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (state_q == ST_IDLE && card_q == '0 && line_q == '0 && ptr_q == '0));
    p_midrow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !(step && wrap) && !restart_i) |=> $stable(state_q));
endmodule

// File: rtl/bg_card_ctrl.sv
module bg_card_ctrl
    import bgc_pkg::*;
#(
    parameter int CARDS = 20,
    parameter int ROWS  = 12,
    parameter int LINES = 16,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_en_i,
    input  logic          cpu_wr_i,
    input  logic [7:0]    cpu_addr_i,
    input  logic [DW-1:0] cpu_wdata_i,
    output logic [DW-1:0] cpu_rdata_o,
    input  logic          busak_n_i,
    input  logic          fetch_i,
    input  logic          restart_i,
    output logic [DW-1:0] card_o,
    output logic          card_vld_o
);
    localparam int ENTRIES = CARDS * ROWS;
    localparam int CW      = $clog2(CARDS);
    localparam int LW      = $clog2(LINES);
    localparam int PW      = $clog2(ENTRIES + 1);
    localparam int AW      = 8;

    bgc_state_e    state;
    logic [CW-1:0] card;
    logic [LW-1:0] line;
    logic [PW-1:0] ptr;
    logic          fetch_q, rise, loading;
    logic [DW-1:0] tbl_word, lb_word, word_d;

    assign rise    = fetch_i && !fetch_q;
    assign loading = (state == ST_FETCH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fetch_q <= 1'b0;
        else        fetch_q <= fetch_i;
    end

    bgc_seq #(.CARDS(CARDS), .LINES(LINES), .ENTRIES(ENTRIES),
              .CW(CW), .LW(LW), .PW(PW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart_i),
        .busak_n_i (busak_n_i),
        .rise_i    (rise),
        .state_o   (state),
        .card_o    (card),
        .line_o    (line),
        .ptr_o     (ptr)
    );

    bgc_table #(.ENTRIES(ENTRIES), .DW(DW), .AW(AW)) u_tbl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_ok_i    (state == ST_IDLE),
        .cpu_en_i    (cpu_en_i),
        .cpu_wr_i    (cpu_wr_i),
        .cpu_addr_i  (cpu_addr_i),
        .cpu_wdata_i (cpu_wdata_i),
        .cpu_rdata_o (cpu_rdata_o),
        .vid_addr_i  (AW'(ptr)),
        .vid_data_o  (tbl_word)
    );

    always_comb begin
        word_d = lb_word;
        if (loading) word_d = (int'(ptr) < ENTRIES) ? tbl_word : '0;
    end

    bgc_linebuf #(.CARDS(CARDS), .DW(DW), .CW(CW)) u_lb (
        .clk     (clk),
        .we_i    (rise && loading),
        .idx_i   (card),
        .wdata_i (word_d),
        .rdata_o (lb_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            card_o     <= '0;
            card_vld_o <= 1'b0;
        end else begin
            card_vld_o <= rise && (state != ST_IDLE);
            if (rise && state != ST_IDLE) card_o <= word_d;
        end
    end

    p_vld_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        card_vld_o |=> !card_vld_o);
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> !card_vld_o);
    p_cpu_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(cpu_rdata_o));
endmodule

// File: tb/bg_card_ctrl_tb.sv
module bg_card_ctrl_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cpu_en_i = 0, cpu_wr_i = 0, busak_n_i = 1, fetch_i = 0, restart_i = 0;
    logic [7:0]  cpu_addr_i = '0;
    logic [15:0] cpu_wdata_i = '0, cpu_rdata_o, card_o;
    logic        card_vld_o;

    int n_chk = 0, n_fail = 0;
    logic [15:0] tbl [240];
    logic [15:0] mlb [20];
    int m_ptr = 0, m_card = 0, m_line = 0;
    bit m_fetch = 1;
    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_P/2) clk = ~clk;

    bg_card_ctrl u_dut (.*);

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && card_vld_o) begin
            if (exp_q.size() == 0) check("R5 unexpected", card_o, 16'hxxxx);
            else check(tag_q.pop_front(), card_o, exp_q.pop_front());
        end
    end

    task automatic cpu_wr(int a, logic [15:0] d);
        @(negedge clk);
        cpu_en_i = 1; cpu_wr_i = 1; cpu_addr_i = 8'(a); cpu_wdata_i = d;
        @(negedge clk);
        cpu_en_i = 0; cpu_wr_i = 0;
    endtask

    task automatic cpu_rd(int a);
        @(negedge clk);
        cpu_en_i = 1; cpu_wr_i = 0; cpu_addr_i = 8'(a);
        @(negedge clk);
        cpu_en_i = 0;
    endtask

    // driver: model from requirements, push expectation, toggle strobe
    task automatic strobe(string t);
        logic [15:0] e;
        string tg;
        if (m_fetch) begin
            e = (m_ptr < 240) ? tbl[m_ptr] : 16'h0;
            tg = (m_ptr >= 240) ? "R9 saturated" : t;
            mlb[m_card] = e;
            if (m_ptr < 240) m_ptr++;
        end else begin
            e = mlb[m_card];
            tg = (t == "R4") ? "R6" : t;
        end
        m_card++;
        if (m_card == 20) begin
            m_card = 0;
            m_line = (m_line + 1) % 16;
            m_fetch = (m_line == 0) && !busak_n_i;
        end
        exp_q.push_back(e);
        tag_q.push_back(tg);
        @(negedge clk); fetch_i = 1;
        @(negedge clk); fetch_i = 0;
    endtask

    task automatic run_line(string t);
        for (int c = 0; c < 20; c++) strobe(t);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 240; i++) tbl[i] = 16'(i * 97 + 16'h1234);
        repeat (3) @(negedge clk);
        check("R1 vld", {15'b0, card_vld_o}, 16'h0);
        check("R1 rdata", cpu_rdata_o, 16'h0);
        rst_n = 1;
        check("R1 vld after release", {15'b0, card_vld_o}, 16'h0);
        // strobe in CPU mode must yield nothing (R1/R10 idle)
        @(negedge clk); fetch_i = 1; @(negedge clk); fetch_i = 0; @(negedge clk);
        for (int i = 0; i < 240; i++) cpu_wr(i, tbl[i]);
        cpu_rd(0);   check("R2 rd 0", cpu_rdata_o, tbl[0]);
        cpu_rd(239); check("R2 rd 239", cpu_rdata_o, tbl[239]);
        cpu_rd(7);   check("R2 rd 7", cpu_rdata_o, tbl[7]);

        // enter display
        @(negedge clk); busak_n_i = 0;
        @(negedge clk);
        // CPU write and read while displaying: ignored (R3)
        cpu_wr(25, 16'hDEAD);
        cpu_rd(100);
        check("R3 rdata held", cpu_rdata_o, tbl[7]);

        // row 0: first strobe checks R4
        strobe("R4");
        for (int c = 1; c < 20; c++) strobe("R5");
        for (int l = 1; l < 16; l++) run_line("R6");
        // row 1 loaded (ack low at boundary), card 5 holds old value (R3)
        run_line("R7");
        for (int l = 1; l < 15; l++) run_line("R6");
        // drop ack before boundary: row 1 must repeat
        @(negedge clk); busak_n_i = 1;
        run_line("R8");
        for (int l = 1; l < 10; l++) run_line("R8");
        // early ack mid-period does not advance
        @(negedge clk); busak_n_i = 0;
        for (int l = 10; l < 16; l++) run_line("R8");
        // rows 2..11, then saturated zeros
        for (int r = 2; r < 13; r++)
            for (int l = 0; l < 16; l++) run_line(l == 0 ? "R7" : "R6");
        check("R9 model pointer", 16'(m_ptr), 16'd240);

        // restart
        @(negedge clk); restart_i = 1; busak_n_i = 1;
        @(negedge clk); restart_i = 0;
        m_ptr = 0; m_card = 0; m_line = 0; m_fetch = 1;
        cpu_rd(25); check("R10 cpu mode back / R3 write dropped", cpu_rdata_o, tbl[25]);
        @(negedge clk); busak_n_i = 0;
        @(negedge clk);
        run_line("R10");
        repeat (3) @(negedge clk);
        check("R5 queue drained", 16'(exp_q.size()), 16'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule